// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a single-data-rate SDRAM interface and owns the command pins from reset until the memory is ready for use. After a synchronous reset it drives a quiet bus with clock enable and data mask high. It keeps the bus quiet for a stabilisation interval, which it derives from the clock frequency. It then closes every bank with one precharge and runs the initialization steps: a group of auto-refresh commands and one load of the mode register. A parameter sets the order of those two steps.

Each command is followed by a parameterised run of NOP cycles so that the memory's recovery times are met. After the last recovery run the block raises `init_done`, and a normal-operation controller may take over the pins from that cycle. A synchronous reset at any point throws away all progress and starts again from the stabilisation wait.

Top module: `sdram_boot_seq`

## Requirements
- R1: From the first cycle after reset onward, `cke` and `dqm` are high and `cs_n` is low in every cycle.
- R2: For exactly W = CLK_MHZ × WAIT_US cycles, the pins carry NOP (ras_n, cas_n, we_n = 1,1,1). These are cycles 0 to W−1, where cycle 0 is the first cycle after the last clock edge seen with `rst` high. No other command appears in that window.
- R3: In cycle W, a precharge (ras_n, cas_n, we_n = 0,1,0) is issued with address bit AP_BIT (bit 10 by default) high, so that all banks close.
- R4: The number of auto-refresh commands (0,0,1) is the larger of REFRESH_COUNT and 2.
- R5: The mode-register load (0,0,0) drives MODE_WORD on `addr` and zero on `ba`.
- R6: When MRS_FIRST = 0, all refreshes come before the mode-register load. When MRS_FIRST = 1, the mode-register load comes first.
- R7: Every command is followed by NOP cycles before the next command or before completion. There are GAP_PRE of them after a precharge, GAP_REF after each refresh and GAP_MRS after the mode-register load.
- R8: `init_done` rises in the cycle after the last recovery NOP of the final command. It then stays high, with only NOPs on the pins, until reset.
- R9: A synchronous reset restarts the whole sequence from cycle 0 with `init_done` low. This holds wherever the sequence has reached, including an edge on which a command would otherwise have been issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cke | output | 1 | Clock enable to the memory |
| dqm | output | 1 | Data mask to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus (precharge-all bit, mode word) |
| ba | output | BA_W | Bank address |
| init_done | output | 1 | Initialization complete, sticky until reset |

## Verification
Restart and command issue can land in the same cycle. The bench provokes this by raising reset exactly in the last wait cycle, when the precharge would be issued on the next edge. It passes only if the following cycle shows a NOP with `init_done` low, and the complete schedule then repeats from cycle 0. A second restart, in the middle of the refresh group, is judged the same way. Two configurations with opposite step order run side by side. Every cycle of each is compared with a schedule that the bench builds arithmetically from the parameters.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;

    // Command issued on the memory pins for one cycle.
    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_PRE = 2'd1,
        CMD_REF = 2'd2,
        CMD_MRS = 2'd3
    } boot_cmd_e;

    // Step of the power-up sequence most recently entered.
    typedef enum logic [2:0] {
        PH_POWER = 3'd0,
        PH_PRE   = 3'd1,
        PH_REF   = 3'd2,
        PH_MRS   = 3'd3,
        PH_DONE  = 3'd4
    } boot_phase_e;

endpackage

// File: rtl/sdram_boot_fsm.sv
module sdram_boot_fsm
    import sdram_boot_pkg::*;
#(
    parameter int CLK_MHZ       = 125,
    parameter int WAIT_US       = 200,
    parameter int REFRESH_COUNT = 2,
    parameter int GAP_PRE       = 3,
    parameter int GAP_REF       = 8,
    parameter int GAP_MRS       = 2,
    parameter int MRS_FIRST     = 0
) (
    input  logic      clk,
    input  logic      rst,
    output boot_cmd_e cmd,
    output logic      done
);

    localparam int WAIT_RAW = CLK_MHZ * WAIT_US;
    localparam int WAIT_CYC = (WAIT_RAW < 1) ? 1 : WAIT_RAW;
    localparam int G_PRE    = (GAP_PRE < 1) ? 1 : GAP_PRE;
    localparam int G_REF    = (GAP_REF < 1) ? 1 : GAP_REF;
    localparam int G_MRS    = (GAP_MRS < 1) ? 1 : GAP_MRS;
    localparam int NREF     = (REFRESH_COUNT < 2) ? 2 : REFRESH_COUNT;
    localparam int MAX_G1   = (G_PRE > G_REF) ? G_PRE : G_REF;
    localparam int MAX_G2   = (MAX_G1 > G_MRS) ? MAX_G1 : G_MRS;
    localparam int MAX_CNT  = (WAIT_CYC - 1 > MAX_G2) ? WAIT_CYC - 1 : MAX_G2;
    localparam int CNT_W    = $clog2(MAX_CNT + 1);
    localparam int REF_W    = $clog2(NREF + 1);

    typedef struct packed {
        boot_phase_e      phase;
        logic [CNT_W-1:0] cnt;
        logic [REF_W-1:0] refs;
        boot_cmd_e        cmd;
        logic             done;
    } seq_t;

    seq_t s_d, s_q;

    // Put a command on the bus and load its recovery gap.
    function automatic seq_t issue(input seq_t cur, input boot_cmd_e c);
        seq_t r;
        r     = cur;
        r.cmd = c;
        case (c)
            CMD_PRE: begin
                r.phase = PH_PRE;
                r.cnt   = CNT_W'(G_PRE);
            end
            CMD_REF: begin
                r.phase = PH_REF;
                r.cnt   = CNT_W'(G_REF);
                r.refs  = cur.refs - REF_W'(1);
            end
            CMD_MRS: begin
                r.phase = PH_MRS;
                r.cnt   = CNT_W'(G_MRS);
            end
            default: r.cnt = '0;
        endcase
        return r;
    endfunction

    function automatic seq_t finish(input seq_t cur);
        seq_t r;
        r       = cur;
        r.cmd   = CMD_NOP;
        r.phase = PH_DONE;
        r.done  = 1'b1;
        return r;
    endfunction

    always_comb begin
        s_d     = s_q;
        s_d.cmd = CMD_NOP;
        if (s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - CNT_W'(1);
        end else begin
            case (s_q.phase)
                PH_POWER: s_d = issue(s_q, CMD_PRE);
                PH_PRE: begin
                    if (MRS_FIRST != 0) s_d = issue(s_q, CMD_MRS);
                    else                s_d = issue(s_q, CMD_REF);
                end
                PH_REF: begin
                    if (s_q.refs != '0)      s_d = issue(s_q, CMD_REF);
                    else if (MRS_FIRST != 0) s_d = finish(s_q);
                    else                     s_d = issue(s_q, CMD_MRS);
                end
                PH_MRS: begin
                    if (MRS_FIRST != 0) s_d = issue(s_q, CMD_REF);
                    else                s_d = finish(s_q);
                end
                default: s_d.cnt = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.phase <= PH_POWER;
            s_q.cnt   <= CNT_W'(WAIT_CYC - 1);
            s_q.refs  <= REF_W'(NREF);
            s_q.cmd   <= CMD_NOP;
            s_q.done  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cmd  = s_q.cmd;
    assign done = s_q.done;

    // R2: nothing but NOP while the stabilisation wait runs
    p_wait_nop_r2: assert property (@(posedge clk) disable iff (rst)
        (s_q.phase == PH_POWER) |-> (cmd == CMD_NOP));

    // R7: every command is followed by at least one NOP
    p_gap_after_cmd_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd != CMD_NOP) |=> (cmd == CMD_NOP));

    // R4: completion only once the refresh budget is spent
    p_refs_spent_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (s_q.refs == '0));

    // R8: completion is sticky
    p_done_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

endmodule

// File: rtl/sdram_boot_pins.sv
module sdram_boot_pins
    import sdram_boot_pkg::*;
#(
    parameter int               ADDR_W    = 11,
    parameter int               BA_W      = 1,
    parameter int               AP_BIT    = 10,
    parameter logic [ADDR_W-1:0] MODE_WORD = '0
) (
    input  boot_cmd_e         cmd,
    output logic              cke,
    output logic              dqm,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba
);

    localparam logic [ADDR_W-1:0] AP_MASK = ADDR_W'(1) << AP_BIT;

    always_comb begin
        cke   = 1'b1;
        dqm   = 1'b1;
        cs_n  = 1'b0;
        ras_n = 1'b1;
        cas_n = 1'b1;
        we_n  = 1'b1;
        addr  = '0;
        ba    = '0;
        case (cmd)
            CMD_PRE: begin
                ras_n = 1'b0;
                we_n  = 1'b0;
                addr  = AP_MASK;
            end
            CMD_REF: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
            end
            CMD_MRS: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
                we_n  = 1'b0;
                addr  = MODE_WORD;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
    import sdram_boot_pkg::*;
#(
    parameter int               CLK_MHZ       = 125,
    parameter int               WAIT_US       = 200,
    parameter int               REFRESH_COUNT = 2,
    parameter int               GAP_PRE       = 3,
    parameter int               GAP_REF       = 8,
    parameter int               GAP_MRS       = 2,
    parameter int               MRS_FIRST     = 0,
    parameter int               ADDR_W        = 11,
    parameter int               BA_W          = 1,
    parameter int               AP_BIT        = 10,
    parameter logic [ADDR_W-1:0] MODE_WORD    = 11'h033
) (
    input  logic              clk,
    input  logic              rst,
    output logic              cke,
    output logic              dqm,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba,
    output logic              init_done
);

    boot_cmd_e cur_cmd;

    sdram_boot_fsm #(
        .CLK_MHZ      (CLK_MHZ),
        .WAIT_US      (WAIT_US),
        .REFRESH_COUNT(REFRESH_COUNT),
        .GAP_PRE      (GAP_PRE),
        .GAP_REF      (GAP_REF),
        .GAP_MRS      (GAP_MRS),
        .MRS_FIRST    (MRS_FIRST)
    ) u_fsm (
        .clk (clk),
        .rst (rst),
        .cmd (cur_cmd),
        .done(init_done)
    );

    sdram_boot_pins #(
        .ADDR_W   (ADDR_W),
        .BA_W     (BA_W),
        .AP_BIT   (AP_BIT),
        .MODE_WORD(MODE_WORD)
    ) u_pins (
        .cmd  (cur_cmd),
        .cke  (cke),
        .dqm  (dqm),
        .cs_n (cs_n),
        .ras_n(ras_n),
        .cas_n(cas_n),
        .we_n (we_n),
        .addr (addr),
        .ba   (ba)
    );

    // R1: enable and mask high, device selected
    p_pins_static_r1: assert property (@(posedge clk) disable iff (rst)
        cke && dqm && !cs_n);

    // R3: precharge closes all banks
    p_prech_all_r3: assert property (@(posedge clk) disable iff (rst)
        (!ras_n && cas_n && !we_n) |-> addr[AP_BIT]);

    // R5: mode load carries the mode word on bank zero
    p_mode_word_r5: assert property (@(posedge clk) disable iff (rst)
        (!ras_n && !cas_n && !we_n) |-> ((addr == MODE_WORD) && (ba == '0)));

    // R8: bus stays idle once initialization has completed
    p_done_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        init_done |-> (ras_n && cas_n && we_n));

endmodule

// File: tb/test_sdram_boot_seq.sv
module test_sdram_boot_seq;

    localparam int CYC = 8;
    // configuration A: refresh group first
    localparam int AW = 20, AGP = 2, AGR = 4, AGM = 3, ANR = 3;
    localparam logic [10:0] AMODE = 11'h033;
    // configuration B: mode load first, refresh count clamped up to 2
    localparam int BW = 16, BGP = 3, BGR = 2, BGM = 2, BNR = 2;
    localparam logic [10:0] BMODE = 11'h227;
    localparam int LAST = 50;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CYC/2) clk = ~clk;

    logic a_cke, a_dqm, a_cs, a_ras, a_cas, a_we, a_done;
    logic [10:0] a_addr;
    logic [0:0]  a_ba;
    logic b_cke, b_dqm, b_cs, b_ras, b_cas, b_we, b_done;
    logic [10:0] b_addr;
    logic [0:0]  b_ba;

    int tests = 0;
    int fails = 0;

    sdram_boot_seq #(
        .CLK_MHZ(1), .WAIT_US(20), .REFRESH_COUNT(3),
        .GAP_PRE(AGP), .GAP_REF(AGR), .GAP_MRS(AGM),
        .MRS_FIRST(0), .MODE_WORD(AMODE)
    ) i_sdram_boot_seq (
        .clk(clk), .rst(rst), .cke(a_cke), .dqm(a_dqm), .cs_n(a_cs),
        .ras_n(a_ras), .cas_n(a_cas), .we_n(a_we), .addr(a_addr),
        .ba(a_ba), .init_done(a_done)
    );

    sdram_boot_seq #(
        .CLK_MHZ(2), .WAIT_US(8), .REFRESH_COUNT(1),
        .GAP_PRE(BGP), .GAP_REF(BGR), .GAP_MRS(BGM),
        .MRS_FIRST(1), .MODE_WORD(BMODE)
    ) i_sdram_boot_seq_mf (
        .clk(clk), .rst(rst), .cke(b_cke), .dqm(b_dqm), .cs_n(b_cs),
        .ras_n(b_ras), .cas_n(b_cas), .we_n(b_we), .addr(b_addr),
        .ba(b_ba), .init_done(b_done)
    );

    // Expected schedule: code 0 NOP, 1 precharge, 2 refresh, 3 mode load;
    // with want_end set, returns the cycle in which completion rises.
    function automatic int walk(input int n, input int w, input int gp,
                                input int gr, input int gm, input int nref,
                                input int mf, input bit want_end);
        int t;
        int code;
        t = w;
        code = 0;
        if (n == t) code = 1;
        t += 1 + gp;
        if (mf != 0) begin
            if (n == t) code = 3;
            t += 1 + gm;
        end
        for (int i = 0; i < nref; i++) begin
            if (n == t) code = 2;
            t += 1 + gr;
        end
        if (mf == 0) begin
            if (n == t) code = 3;
            t += 1 + gm;
        end
        return want_end ? t : code;
    endfunction

    function automatic int decode(input logic ras, input logic cas, input logic we);
        case ({ras, cas, we})
            3'b111:  return 0;
            3'b010:  return 1;
            3'b001:  return 2;
            3'b000:  return 3;
            default: return 9;
        endcase
    endfunction

    task automatic chk(input bit ok, input string rid, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", rid, what, act, exp);
        end
    endtask

    task automatic check_one(input string tag, input int n,
                             input logic cke, input logic dqm, input logic cs,
                             input logic ras, input logic cas, input logic we,
                             input logic [10:0] addr, input logic [0:0] ba,
                             input logic done, input int w, input int gp,
                             input int gr, input int gm, input int nref,
                             input int mf, input logic [10:0] mode);
        int act, exp, endt;
        act  = decode(ras, cas, we);
        exp  = walk(n, w, gp, gr, gm, nref, mf, 1'b0);
        endt = walk(n, w, gp, gr, gm, nref, mf, 1'b1);
        // R1 static pins
        chk(cke === 1'b1 && dqm === 1'b1 && cs === 1'b0, "R1",
            {tag, " cke/dqm/cs_n"}, int'({cke, dqm, cs}), 6);
        // R2 wait window, R4/R6/R7 schedule order and gaps
        if (n < w)
            chk(act == 0, "R2", {tag, " wait cmd"}, act, 0);
        else if (exp == 2 || act == 2)
            chk(act == exp, "R4", {tag, " refresh slot"}, act, exp);
        else
            chk(act == exp, exp == 0 ? "R7" : "R6", {tag, " cmd"}, act, exp);
        if (exp == 1)
            chk(addr[10] === 1'b1, "R3", {tag, " precharge-all bit"}, int'(addr), 11'h400);
        if (exp == 3)
            chk(addr === mode && ba === 1'b0, "R5", {tag, " mode word"},
                int'(addr), int'(mode));
        chk(done === (n >= endt), "R8", {tag, " init_done"}, int'(done), int'(n >= endt));
    endtask

    task automatic check_both(input int n);
        check_one("A", n, a_cke, a_dqm, a_cs, a_ras, a_cas, a_we, a_addr, a_ba,
                  a_done, AW, AGP, AGR, AGM, ANR, 0, AMODE);
        check_one("B", n, b_cke, b_dqm, b_cs, b_ras, b_cas, b_we, b_addr, b_ba,
                  b_done, BW, BGP, BGR, BGM, BNR, 1, BMODE);
    endtask

    // Called at a falling edge; leaves the bench at the falling edge of cycle 0.
    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_span(input int last);
        for (int n = 0; n <= last; n++) begin
            if (n > 0) @(negedge clk);
            check_both(n);
        end
    endtask

    initial begin
        #(CYC * 150000);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        do_reset();
        // full schedule of both configurations (R1..R8)
        run_span(LAST);
        // R9: restart in the middle of the refresh group
        do_reset();
        run_span(25);
        do_reset();
        chk(a_done === 1'b0 && b_done === 1'b0, "R9", "done after mid reset",
            int'({a_done, b_done}), 0);
        run_span(LAST);
        // R9: reset on the edge that would issue precharge in configuration A
        do_reset();
        run_span(AW - 1);
        do_reset();
        chk(decode(a_ras, a_cas, a_we) == 0, "R9", "reset beats precharge",
            decode(a_ras, a_cas, a_we), 0);
        run_span(LAST);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule